// File: doc/BRIEF.md
# Built-in Self-Test Input Data Source

This block decides what feeds the internal sample bus in front of a filter chain. In normal operation it passes the converter word and its input-enable strobe through unchanged. For self-test it can replace the converter word with a constant negative full-scale word or with a pseudo-random word taken from a linear feedback shift register.

Independently of the data choice, it can make the bus look like a time-multiplexed dual-input converter. In that mode the external enable is ignored and the internal enable alternates on every clock, as an A/B channel select would. The pseudo-random generator steps only on cycles where the internal enable is high, so the test pattern follows the sample rate the filters actually see. Both outputs are registered, and each has one cycle of latency from the inputs.

Top module: `bist_data_src`

## Requirements
- R1: The reset is synchronous and active high. After reset, `bus_data` and `bus_en` are 0, and the generator state is 15'h0001, so the first pseudo-random word is 14'h0001.
- R2: While `test_en` is 0, `bus_data` equals `adc_data` from the previous cycle.
- R3: While `test_en` is 1 and `prbs_sel` is 0, `bus_data` is 14'h2000, the most negative 14-bit two's complement value, on the next cycle.
- R4: While `test_en` and `prbs_sel` are both 1, `bus_data` on the next cycle is the low 14 bits of the generator state. One step moves every state bit up by one place and loads state[14] XOR state[13] into bit 0, which implements x^15+x^14+1.
- R5: The generator holds its state on every cycle where the internal enable is 0.
- R6: While `ilv_emul` is 0, the internal enable equals `adc_en`, and `bus_en` equals `adc_en` from the previous cycle.
- R7: While `ilv_emul` is 1, the internal enable alternates every cycle, starting at 0 on the first cycle of the mode, and `bus_en` shows it one cycle later. `adc_en` has no effect on either output in this mode.
- R8: With the generator stepping on every cycle, the pseudo-random output repeats after exactly 32767 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | 14 | Converter sample, two's complement |
| adc_en | input | 1 | Converter input-enable strobe |
| test_en | input | 1 | 1 selects the internal test source |
| prbs_sel | input | 1 | With test_en high: 0 selects the constant, 1 selects the pseudo-random word |
| ilv_emul | input | 1 | 1 forces the internal enable to alternate every cycle |
| bus_data | output | 14 | Registered word on the internal bus |
| bus_en | output | 1 | Registered internal input enable |

## Verification
The bench builds the block with its default parameters: a 14-bit data word and a 15-bit generator. At these sizes the whole generator cycle takes 32767 steps, so the bench can run it end to end and see the first word come back after exactly that many enabled cycles. Random mixes of the mode bits, the strobe and mid-run resets exercise the interaction between the alternating enable and the generator's stepping.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [1:0] {
    SRC_ADC   = 2'd0,
    SRC_NEGFS = 2'd1,
    SRC_PRBS  = 2'd2
  } src_sel_e;

  function automatic src_sel_e pick_src(input logic test_en, input logic prbs_sel);
    if (!test_en)      return SRC_ADC;
    else if (prbs_sel) return SRC_PRBS;
    else               return SRC_NEGFS;
  endfunction

endpackage

// File: rtl/bist_en_toggler.sv
module bist_en_toggler (
  input  logic clk,
  input  logic rst,
  input  logic ilv_emul,
  input  logic adc_en,
  output logic en_int
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= 1'b0;
    else if (ilv_emul) phase_q <= ~phase_q;
    else               phase_q <= 1'b0;
  end

  assign en_int = ilv_emul ? phase_q : adc_en;
endmodule

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int          LFSR_W = 15,
  parameter int          TAP_HI = 15,
  parameter int          TAP_LO = 14,
  parameter logic [14:0] SEED   = 15'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = state_q[TAP_HI-1] ^ state_q[TAP_LO-1];

  always_ff @(posedge clk) begin
    if (rst)      state_q <= LFSR_W'(SEED);
    else if (adv) state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign state = state_q;
endmodule

// File: rtl/bist_data_mux.sv
module bist_data_mux #(
  parameter int DATA_W = 14,
  parameter int LFSR_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  bist_pkg::src_sel_e  src,
  input  logic [DATA_W-1:0]   adc_data,
  input  logic [LFSR_W-1:0]   prbs_state,
  input  logic                en_int,
  output logic [DATA_W-1:0]   bus_data,
  output logic                bus_en
);
  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] prbs_word;
  logic [DATA_W-1:0] mux_d;

  generate
    if (DATA_W <= LFSR_W) begin : g_slice
      assign prbs_word = prbs_state[DATA_W-1:0];
    end else begin : g_pad
      assign prbs_word = {{(DATA_W-LFSR_W){1'b0}}, prbs_state};
    end
  endgenerate

  always_comb begin
    unique case (src)
      bist_pkg::SRC_NEGFS: mux_d = NEG_FS;
      bist_pkg::SRC_PRBS:  mux_d = prbs_word;
      default:             mux_d = adc_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data <= '0;
      bus_en   <= 1'b0;
    end else begin
      bus_data <= mux_d;
      bus_en   <= en_int;
    end
  end
endmodule

// File: rtl/bist_data_src.sv
module bist_data_src #(
  parameter int          DATA_W = 14,
  parameter int          LFSR_W = 15,
  parameter int          TAP_HI = 15,
  parameter int          TAP_LO = 14,
  parameter logic [14:0] SEED   = 15'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_en,
  input  logic              test_en,
  input  logic              prbs_sel,
  input  logic              ilv_emul,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_en
);
  logic               en_int;
  logic [LFSR_W-1:0]  prbs_state;
  bist_pkg::src_sel_e src;

  assign src = bist_pkg::pick_src(test_en, prbs_sel);

  bist_en_toggler u_tog (
    .clk      (clk),
    .rst      (rst),
    .ilv_emul (ilv_emul),
    .adc_en   (adc_en),
    .en_int   (en_int)
  );

  bist_lfsr #(
    .LFSR_W (LFSR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO),
    .SEED   (SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .adv   (en_int),
    .state (prbs_state)
  );

  bist_data_mux #(
    .DATA_W (DATA_W),
    .LFSR_W (LFSR_W)
  ) u_mux (
    .clk        (clk),
    .rst        (rst),
    .src        (src),
    .adc_data   (adc_data),
    .prbs_state (prbs_state),
    .en_int     (en_int),
    .bus_data   (bus_data),
    .bus_en     (bus_en)
  );
endmodule

// File: rtl/bist_data_src_chk.sv
module bist_data_src_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] adc_data,
  input logic              adc_en,
  input logic              test_en,
  input logic              prbs_sel,
  input logic              ilv_emul,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_en
);
  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> bus_data == $past(adc_data));

  // R3
  neg_fs_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en && !prbs_sel) |=> bus_data == NEG_FS);

  // R4
  prbs_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en && prbs_sel && !ilv_emul && adc_en) ##1 (test_en && prbs_sel)
    |=> bus_data[DATA_W-1:1] == $past(bus_data[DATA_W-2:0]));

  // R5
  prbs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en && prbs_sel && !ilv_emul && !adc_en) ##1 (test_en && prbs_sel)
    |=> $stable(bus_data));

  // R6
  en_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !ilv_emul |=> bus_en == $past(adc_en));

  // R7
  en_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    ilv_emul ##1 ilv_emul |=> bus_en != $past(bus_en));
endmodule

bind bist_data_src bist_data_src_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .adc_data (adc_data),
  .adc_en   (adc_en),
  .test_en  (test_en),
  .prbs_sel (prbs_sel),
  .ilv_emul (ilv_emul),
  .bus_data (bus_data),
  .bus_en   (bus_en)
);

// File: tb/bist_data_src_tb.sv
module bist_data_src_tb;
  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] adc_data = '0;
  logic          adc_en = 1'b0, test_en = 1'b0, prbs_sel = 1'b0, ilv_emul = 1'b0;
  logic [DW-1:0] bus_data;
  logic          bus_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [14:0]   m_lfsr;
  logic          m_tgl;
  logic [DW-1:0] exp_data;
  logic          exp_en;

  always #2 clk = ~clk;

  bist_data_src u_dut (
    .clk(clk), .rst(rst), .adc_data(adc_data), .adc_en(adc_en),
    .test_en(test_en), .prbs_sel(prbs_sel), .ilv_emul(ilv_emul),
    .bus_data(bus_data), .bus_en(bus_en)
  );

  function automatic logic [14:0] lfsr_step(input logic [14:0] q);
    return {q[13:0], q[14] ^ q[13]};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (bus_data !== exp_data || bus_en !== exp_en) begin
      errors++;
      $display("FAIL %s: data=%h en=%b expected data=%h en=%b",
               tag, bus_data, bus_en, exp_data, exp_en);
    end
  endtask

  // Check what the last edge produced, then apply new inputs and predict the next edge.
  task automatic step(input logic r, input logic t, input logic p, input logic e,
                      input logic ae, input logic [DW-1:0] d, input string tag);
    logic en_i;
    @(negedge clk);
    check(tag);
    rst = r; test_en = t; prbs_sel = p; ilv_emul = e; adc_en = ae; adc_data = d;
    if (r) begin
      exp_data = '0; exp_en = 1'b0; m_lfsr = 15'h0001; m_tgl = 1'b0;
    end else begin
      en_i     = e ? m_tgl : ae;
      exp_en   = en_i;
      exp_data = !t ? d : (p ? m_lfsr[DW-1:0] : 14'h2000);
      m_tgl    = e ? ~m_tgl : 1'b0;
      if (en_i) m_lfsr = lfsr_step(m_lfsr);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] first_word;
    void'($urandom(32'd2024));
    m_lfsr = 15'h0001; m_tgl = 1'b0; exp_data = '0; exp_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state, then the seed word appears first
    step(0, 1, 1, 0, 1, '0, "R1");
    step(0, 1, 1, 0, 1, '0, "R1");
    // R2 / R6: pass-through with random strobe
    for (int i = 0; i < 200; i++) step(0, 0, $urandom, 0, $urandom, DW'($urandom), "R2_R6");
    // R3: constant word regardless of converter input
    for (int i = 0; i < 50; i++) step(0, 1, 0, 0, $urandom, DW'($urandom), "R3");
    // R4: pseudo-random words, strobe random
    for (int i = 0; i < 200; i++) step(0, 1, 1, 0, $urandom, DW'($urandom), "R4");
    // R5: strobe low, word must hold
    for (int i = 0; i < 30; i++) step(0, 1, 1, 0, 0, DW'($urandom), "R5");
    // R7: alternating enable, converter strobe ignored
    for (int i = 0; i < 100; i++) step(0, 1, 1, 1, $urandom, DW'($urandom), "R7");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, DW'($urandom), "R7");
    // R8: full period from reset
    step(1, 1, 1, 0, 1, '0, "R8");
    step(0, 1, 1, 0, 1, '0, "R8");
    @(negedge clk);
    check("R8");
    first_word = bus_data;
    rst = 0; test_en = 1; prbs_sel = 1; ilv_emul = 0; adc_en = 1;
    exp_data = m_lfsr[DW-1:0]; exp_en = 1'b1; m_lfsr = lfsr_step(m_lfsr);
    for (int i = 1; i < 32767; i++) step(0, 1, 1, 0, 1, '0, "R8");
    @(negedge clk);
    check("R8");
    checks++;
    if (bus_data !== first_word || first_word !== 14'h0001) begin
      errors++;
      $display("FAIL R8: word after period=%h expected %h", bus_data, first_word);
    end
    exp_data = m_lfsr[DW-1:0]; exp_en = 1'b1; m_lfsr = lfsr_step(m_lfsr);
    // Random mix with occasional resets
    for (int i = 0; i < 2000; i++)
      step(($urandom % 97) == 0, $urandom, $urandom, ($urandom % 3) == 0, $urandom,
           DW'($urandom), "MIX_R1_R7");
    @(negedge clk);
    check("MIX_R1_R7");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule